// File: doc/BRIEF.md
# Event Performance Monitoring Unit

This block counts hardware events for profiling. It has four event counters and one cycle counter, all 32 bits wide. Each event counter picks one line out of a 64-bit event vector. It counts that line in one of two modes:

- **Occurrence mode:** one count per rising edge of the line.
- **Duration mode:** one count per clock while the line is high.

The cycle counter advances on every clock while counting is globally enabled. It gives a time base against which duration counts can be read as a fraction of run time.

A counter that passes all-ones wraps to zero, keeps counting and latches a sticky overflow flag. An interrupt output is raised while any flag is set whose matching interrupt enable bit is also set.

Software reaches the registers through a simple register port. The port carries a valid strobe, a write flag, a privilege flag and two 4-bit register numbers (primary and secondary). Reads return data combinationally in the same cycle. Writes take effect at the next clock edge.

Top module: `perf_mon_unit`

## Requirements
- R1: When global enable (control bit 0) is 1, an event counter whose code has bit 7 clear counts +1 for each clock edge at which its selected event line is 1 and was 0 at the previous edge.
- R2: An event counter whose code has bit 7 set counts +1 at every clock edge at which its selected line is 1, while global enable is 1.
- R3: The cycle counter counts +1 at every clock edge while global enable is 1. No counter changes while global enable is 0.
- R4: A counter at all-ones that increments wraps to zero, keeps counting afterwards, and sets its overflow flag. Flag bits 0 to 3 belong to event counters 0 to 3, and bit 4 belongs to the cycle counter.
- R5: `irq_o` is 1 exactly when some flag bit is set together with the same bit of the interrupt enable register (bits 0 to 4).
- R6: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set and a clear of the same bit in one cycle leave the bit set.
- R7: The register map uses (primary, secondary) numbers as follows. Control is at (0,1), the cycle counter at (1,1), interrupt enable at (4,1) with 5 bits, flags at (5,1) and event select at (8,1). Event counter n is at (n,2). Unmapped addresses read 0 and ignore writes.
- R8: Accesses with `req_priv_i` low change nothing, and their reads return 0.
- R9: Writing 1 to control bit 1 clears all event counters, and writing 1 to control bit 2 clears the cycle counter. Both bits read back 0, and a clear beats an increment in the same cycle.
- R10: A software write to a counter in the same cycle as an increment stores the written value and sets no flag.
- R11: Event select holds one 8-bit code per counter, with counter n in bits [8n+7:8n]. Bits [5:0] index the event vector, bit 7 picks duration mode, and all 32 bits read back as written.
- R12: After reset, all registers read 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 64 | Event lines from the monitored logic |
| req_valid_i | input | 1 | Register access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_priv_i | input | 1 | Access is privileged |
| req_crn_i | input | 4 | Primary register number |
| req_crm_i | input | 4 | Secondary register number |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid in the cycle of a read |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions assume three things about the inputs:
- the event lines and register requests are stable around each rising edge;
- a counter's increment, clear and write requests can coincide in any combination;
- no check looks at cycles before reset is released.

The stimulus drives every input on the falling edge, so that assumption always holds. Register reads are sampled a short time after the falling edge, before the next rising edge. Sequences that overflow are built by preloading a counter to all-ones, or one short of it, through a software write. No test has to run 2^32 cycles to reach an overflow.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  typedef enum logic [2:0] {K_NONE, K_CTRL, K_CYC, K_IEN, K_FLG, K_SEL, K_EVT} reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] idx;
  } reg_sel_t;

  localparam int CTRL_EN      = 0;
  localparam int CTRL_RST_EV  = 1;
  localparam int CTRL_RST_CYC = 2;

  function automatic reg_sel_t decode_addr(input logic [3:0] crn, input logic [3:0] crm,
                                           input int num_ev);
    reg_sel_t s;
    s.kind = K_NONE;
    s.idx  = crn;
    if (crm == 4'd1) begin
      case (crn)
        4'd0: s.kind = K_CTRL;
        4'd1: s.kind = K_CYC;
        4'd4: s.kind = K_IEN;
        4'd5: s.kind = K_FLG;
        4'd8: s.kind = K_SEL;
        default: s.kind = K_NONE;
      endcase
    end else if (crm == 4'd2 && int'(crn) < num_ev) begin
      s.kind = K_EVT;
    end
    return s;
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  // priority: clear, then software write, then increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign ovf_o = inc_i & ~clr_i & ~wr_i & (&cnt_q);
  assign cnt_o = cnt_q;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !wr_i && (&cnt_q)) |=> (cnt_q == '0)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i && !wr_i) |=> $stable(cnt_q)); // R3
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> (cnt_q == $past(wdata_i))); // R10
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/pmu_event_src.sv
module pmu_event_src #(
  parameter int EVT_W = 64,
  parameter int IDX_W = 6
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] evt_q_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             dur_i,
  output logic             hit_o
);
  logic now_w, prev_w;

  assign now_w  = evt_i[idx_i];
  assign prev_w = evt_q_i[idx_i];
  // duration: level; occurrence: rising edge
  assign hit_o  = dur_i ? now_w : (now_w & ~prev_w);
endmodule

// File: rtl/pmu_regs.sv
module pmu_regs
  import pmu_pkg::*;
#(
  parameter int NUM_EV = 4,
  parameter int CNT_W  = 32,
  parameter int CODE_W = 8,
  localparam int SEL_W = NUM_EV * CODE_W,
  localparam int FLG_W = NUM_EV + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_wr_i,
  input  reg_sel_t         sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [FLG_W-1:0] ovf_i,
  output logic             en_o,
  output logic             clr_ev_o,
  output logic             clr_cyc_o,
  output logic [FLG_W-1:0] ien_o,
  output logic [FLG_W-1:0] flg_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             irq_o
);
  logic             en_q;
  logic [FLG_W-1:0] ien_q, flg_q, w1c_w;
  logic [SEL_W-1:0] sel_q;
  logic             wr_ctrl, wr_ien, wr_flg, wr_sel;

  assign wr_ctrl = acc_wr_i && sel_i.kind == K_CTRL;
  assign wr_ien  = acc_wr_i && sel_i.kind == K_IEN;
  assign wr_flg  = acc_wr_i && sel_i.kind == K_FLG;
  assign wr_sel  = acc_wr_i && sel_i.kind == K_SEL;

  assign clr_ev_o  = wr_ctrl & wdata_i[CTRL_RST_EV];
  assign clr_cyc_o = wr_ctrl & wdata_i[CTRL_RST_CYC];
  assign w1c_w     = wr_flg ? wdata_i[FLG_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ien_q <= '0;
      sel_q <= '0;
      flg_q <= '0;
    end else begin
      if (wr_ctrl) en_q  <= wdata_i[CTRL_EN];
      if (wr_ien)  ien_q <= wdata_i[FLG_W-1:0];
      if (wr_sel)  sel_q <= wdata_i[SEL_W-1:0];
      flg_q <= (flg_q & ~w1c_w) | ovf_i; // set beats clear
    end
  end

  assign en_o  = en_q;
  assign ien_o = ien_q;
  assign flg_o = flg_q;
  assign sel_o = sel_q;
  assign irq_o = |(flg_q & ien_q);

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_flg |=> ((flg_q & $past(flg_q)) == $past(flg_q))); // R6
  AST_OVF_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ovf_i) |=> ((flg_q & $past(ovf_i)) == $past(ovf_i))); // R4
  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(ovf_i & ien_q)) && !wr_ien) |=> irq_o); // R5
  AST_NO_IRQ_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_q == '0) |-> !irq_o); // R5
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EV = 4,
  parameter int CNT_W  = 32,
  parameter int EVT_W  = 64,
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_priv_i,
  input  logic [3:0]        req_crn_i,
  input  logic [3:0]        req_crm_i,
  input  logic [CNT_W-1:0]  req_wdata_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              irq_o
);
  localparam int IDX_W    = $clog2(EVT_W);
  localparam int EV_IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;
  localparam int SEL_W    = NUM_EV * CODE_W;
  localparam int FLG_W    = NUM_EV + 1;

  reg_sel_t         sel_w;
  logic             acc_w, acc_wr_w;
  logic [EVT_W-1:0] evt_q;
  logic             en_w, clr_ev_w, clr_cyc_w;
  logic [FLG_W-1:0] ien_w, flg_w, ovf_w;
  logic [SEL_W-1:0] evsel_w;
  logic [NUM_EV-1:0] wr_ev_w, hit_w;
  logic [CNT_W-1:0] ev_cnt [NUM_EV];
  logic [CNT_W-1:0] cyc_cnt;
  logic             wr_cyc_w;

  assign sel_w    = decode_addr(req_crn_i, req_crm_i, NUM_EV);
  assign acc_w    = req_valid_i & req_priv_i;
  assign acc_wr_w = acc_w & req_write_i;
  assign wr_cyc_w = acc_wr_w && sel_w.kind == K_CYC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_i;
  end

  pmu_regs #(.NUM_EV(NUM_EV), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_wr_i  (acc_wr_w),
    .sel_i     (sel_w),
    .wdata_i   (req_wdata_i),
    .ovf_i     (ovf_w),
    .en_o      (en_w),
    .clr_ev_o  (clr_ev_w),
    .clr_cyc_o (clr_cyc_w),
    .ien_o     (ien_w),
    .flg_o     (flg_w),
    .sel_o     (evsel_w),
    .irq_o     (irq_o)
  );

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    assign wr_ev_w[i] = acc_wr_w && sel_w.kind == K_EVT && sel_w.idx == 4'(i);

    pmu_event_src #(.EVT_W(EVT_W), .IDX_W(IDX_W)) u_src (
      .evt_i   (evt_i),
      .evt_q_i (evt_q),
      .idx_i   (evsel_w[i*CODE_W +: IDX_W]),
      .dur_i   (evsel_w[i*CODE_W + CODE_W - 1]),
      .hit_o   (hit_w[i])
    );

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (en_w & hit_w[i]),
      .clr_i   (clr_ev_w),
      .wr_i    (wr_ev_w[i]),
      .wdata_i (req_wdata_i),
      .cnt_o   (ev_cnt[i]),
      .ovf_o   (ovf_w[i])
    );

    AST_DURATION_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_w && evsel_w[i*CODE_W + CODE_W - 1] && evt_i[evsel_w[i*CODE_W +: IDX_W]]
       && !clr_ev_w && !wr_ev_w[i])
      |=> (ev_cnt[i] == $past(ev_cnt[i]) + CNT_W'(1))); // R2
  end

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (en_w),
    .clr_i   (clr_cyc_w),
    .wr_i    (wr_cyc_w),
    .wdata_i (req_wdata_i),
    .cnt_o   (cyc_cnt),
    .ovf_o   (ovf_w[NUM_EV])
  );

  always_comb begin
    rd_data_o = '0;
    if (acc_w && !req_write_i) begin
      case (sel_w.kind)
        K_CTRL:  rd_data_o = CNT_W'(en_w);
        K_CYC:   rd_data_o = cyc_cnt;
        K_IEN:   rd_data_o = CNT_W'(ien_w);
        K_FLG:   rd_data_o = CNT_W'(flg_w);
        K_SEL:   rd_data_o = CNT_W'(evsel_w);
        K_EVT:   rd_data_o = ev_cnt[sel_w.idx[EV_IDX_W-1:0]];
        default: rd_data_o = '0;
      endcase
    end
  end

  AST_UNPRIV_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_priv_i) |-> (rd_data_o == '0)); // R8
  AST_UNPRIV_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !req_priv_i)
    |=> ($stable(ien_w) && $stable(evsel_w) && $stable(en_w))); // R8
endmodule

// File: tb/sim_perf_mon_unit.sv
module sim_perf_mon_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt = '0;
  logic        valid = 1'b0, write = 1'b0, priv = 1'b0;
  logic [3:0]  crn = '0, crm = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  perf_mon_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .req_valid_i(valid), .req_write_i(write), .req_priv_i(priv),
    .req_crn_i(crn), .req_crm_i(crm), .req_wdata_i(wdata),
    .rd_data_o(rdata), .irq_o(irq)
  );

  // {priv, write, crn, crm, wdata, expected read}
  localparam int NTBL = 12;
  localparam logic [73:0] TBL [NTBL] = '{
    {1'b1, 1'b1, 4'd4, 4'd1, 32'h0000_00FF, 32'h0},
    {1'b1, 1'b0, 4'd4, 4'd1, 32'h0,         32'h0000_001F}, // R7 five enable bits
    {1'b1, 1'b1, 4'd8, 4'd1, 32'h8142_0503, 32'h0},
    {1'b1, 1'b0, 4'd8, 4'd1, 32'h0,         32'h8142_0503}, // R11
    {1'b0, 1'b1, 4'd4, 4'd1, 32'h0,         32'h0},
    {1'b1, 1'b0, 4'd4, 4'd1, 32'h0,         32'h0000_001F}, // R8 write ignored
    {1'b0, 1'b0, 4'd8, 4'd1, 32'h0,         32'h0},         // R8 read zero
    {1'b1, 1'b0, 4'd2, 4'd1, 32'h0,         32'h0},         // R7 unmapped
    {1'b1, 1'b1, 4'd0, 4'd1, 32'h0000_0006, 32'h0},
    {1'b1, 1'b0, 4'd0, 4'd1, 32'h0,         32'h0},         // R9 self-clearing
    {1'b1, 1'b1, 4'd3, 4'd2, 32'hDEAD_BEEF, 32'h0},
    {1'b1, 1'b0, 4'd3, 4'd2, 32'h0,         32'hDEAD_BEEF}  // R7 counter 3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic p, input logic [3:0] n, input logic [3:0] m,
                        input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; priv = p; crn = n; crm = m; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; priv = 1'b0;
  endtask

  // call at a falling edge; consumes no clock edge
  task automatic rd_reg(input logic p, input logic [3:0] n, input logic [3:0] m,
                        output logic [31:0] q);
    valid = 1'b1; write = 1'b0; priv = p; crn = n; crm = m;
    #2;
    q = rdata;
    valid = 1'b0; priv = 1'b0;
  endtask

  task automatic step_evt(input logic [63:0] v);
    @(negedge clk);
    evt = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd_reg(1, 0, 1, q); check("R12 ctrl", q, 0);
    rd_reg(1, 1, 1, q); check("R12 cycle", q, 0);
    rd_reg(1, 4, 1, q); check("R12 ien", q, 0);
    rd_reg(1, 5, 1, q); check("R12 flags", q, 0);
    rd_reg(1, 8, 1, q); check("R12 evsel", q, 0);
    for (int i = 0; i < 4; i++) begin
      rd_reg(1, 4'(i), 2, q); check("R12 event counter", q, 0);
    end
    check("R12 irq", 32'(irq), 0);

    // table walk
    for (int i = 0; i < NTBL; i++) begin
      if (TBL[i][72]) wr_reg(TBL[i][73], TBL[i][71:68], TBL[i][67:64], TBL[i][63:32]);
      else begin
        @(negedge clk);
        rd_reg(TBL[i][73], TBL[i][71:68], TBL[i][67:64], q);
        check($sformatf("table row %0d (R7/R8/R9/R11)", i), q, TBL[i][31:0]);
      end
    end

    // R1/R2: c0 occ idx3, c1 dur idx3, c2 occ idx5, c3 dur idx0
    wr_reg(1, 8, 1, 32'h8005_8303);
    wr_reg(1, 0, 1, 32'h7);
    step_evt(64'h8); step_evt(64'h8); step_evt(64'h8);
    step_evt(64'h0); step_evt(64'h0); step_evt(64'h8);
    step_evt(64'h0); step_evt(64'h0);
    rd_reg(1, 0, 2, q); check("R1 occurrence edges", q, 2);
    rd_reg(1, 1, 2, q); check("R2 duration cycles", q, 4);
    rd_reg(1, 2, 2, q); check("R1 other line idle", q, 0);

    // R3 cycle counter
    wr_reg(1, 0, 1, 32'h5);
    repeat (10) @(negedge clk);
    wr_reg(1, 0, 1, 32'h0);
    rd_reg(1, 1, 1, q); check("R3 cycle count", q, 12);
    step_evt(64'h8); step_evt(64'h0);
    repeat (3) @(negedge clk);
    rd_reg(1, 1, 1, q); check("R3 cycle held when disabled", q, 12);
    rd_reg(1, 0, 2, q); check("R3 event held when disabled", q, 2);

    // R4/R5/R6 overflow
    wr_reg(1, 0, 1, 32'h1);
    wr_reg(1, 5, 1, 32'h1F);
    wr_reg(1, 4, 1, 32'h04);
    wr_reg(1, 2, 2, 32'hFFFF_FFFE);
    step_evt(64'h20); step_evt(64'h0); step_evt(64'h20); step_evt(64'h0);
    rd_reg(1, 2, 2, q); check("R4 wrap to zero", q, 0);
    rd_reg(1, 5, 1, q); check("R4 flag bit2", q, 32'h04);
    check("R5 irq enabled flag", 32'(irq), 1);
    step_evt(64'h20); step_evt(64'h0);
    rd_reg(1, 2, 2, q); check("R4 counts after wrap", q, 1);
    rd_reg(1, 5, 1, q); check("R6 flag sticky", q, 32'h04);
    wr_reg(1, 3, 2, 32'hFFFF_FFFF);
    step_evt(64'h1); step_evt(64'h0);
    rd_reg(1, 5, 1, q); check("R4 flag bit3", q, 32'h0C);
    wr_reg(1, 5, 1, 32'h04);
    rd_reg(1, 5, 1, q); check("R6 write-one clears", q, 32'h08);
    check("R5 masked flag no irq", 32'(irq), 0);

    // R10 write beats increment
    step_evt(64'h8);
    wr_reg(1, 1, 2, 32'd100);
    rd_reg(1, 1, 2, q); check("R10 write wins", q, 100);
    step_evt(64'h0);
    rd_reg(1, 1, 2, q); check("R2 duration after write", q, 101);
    rd_reg(1, 5, 1, q); check("R10 no flag from write", q, 32'h08);

    // R4 cycle counter overflow, R9 clears
    wr_reg(1, 1, 1, 32'hFFFF_FFFF);
    @(negedge clk);
    rd_reg(1, 5, 1, q); check("R4 cycle flag bit4", q, 32'h18);
    wr_reg(1, 0, 1, 32'h3);
    for (int i = 0; i < 4; i++) begin
      rd_reg(1, 4'(i), 2, q); check("R9 event clear", q, 0);
    end
    rd_reg(1, 0, 1, q); check("R9 ctrl reads enable only", q, 1);
    wr_reg(1, 0, 1, 32'h5);
    rd_reg(1, 1, 1, q); check("R9 cycle clear", q, 0);

    // R8 unprivileged write
    wr_reg(0, 0, 2, 32'h1234);
    rd_reg(1, 0, 2, q); check("R8 unpriv counter write ignored", q, 0);
    rd_reg(0, 1, 1, q); check("R8 unpriv read zero", q, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule